// File: doc/BRIEF.md
# Self-Test Status and Fault Flag Register

This block collects the event pulses produced by an ADC self-test sequencer and holds them as sticky flags until software clears them by writing ones. There are six flags: a sequence error (a step arrived out of order), a timing error (an algorithm ran past its allowed time), an overwrite indication, a self-test end-of-conversion, and one end-of-algorithm flag for each of two test algorithms, called A and B here.

Every error event carries the algorithm it belongs to and the step index at which it happened. The block keeps one step field per algorithm. If a new error arrives while an earlier one is still pending, the overwrite flag is raised. A policy input then decides what happens to the new error. Either it replaces the stored error status and step, or it is dropped.

The block produces a masked, registered interrupt request. It also steers each watchdog error flag to a critical or a non-critical fault line, chosen by a mapping bit per error.

Top module: `selftest_status_reg`

## Requirements
- R1: After reset, all flags, both step fields, the interrupt and both fault outputs are 0.
- R2: The flag positions in `flags` and `wr_data` are: bit 0 sequence error, bit 1 timing error, bit 2 overwrite, bit 3 self-test end-of-conversion, bit 4 end of algorithm A, bit 5 end of algorithm B. A write with `wr_en` high clears every flag whose `wr_data` bit is 1, one cycle later. Bits written as 0 leave their flags unchanged.
- R3: Suppose a sequence or timing error pulse arrives while no error flag (bits 0 and 1) is pending. The matching flag(s) are set on the next cycle. `err_step` is stored in the step field of the algorithm named by `err_algo` (0 = A, 1 = B).
- R4: If a hardware set and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: An error pulse that arrives while bit 0 or bit 1 is set, and is not cleared in that same cycle, sets the overwrite flag.
- R6: When such a newer error arrives and `ovr_en` is 1, bits 0 and 1 take exactly the new event's values and the step field is loaded from `err_step`. When `ovr_en` is 0, the new error is discarded, so the error flags and both step fields are unchanged.
- R7: The self-test end-of-conversion flag sets only on an `eoc_evt` that has `eoc_is_selftest` = 1 and `eoc_mask` = 1.
- R8: The end-of-algorithm flag for A (or B) sets only on that algorithm's done pulse while its watchdog-enable input is 1.
- R9: `irq` is a register. It is 1 exactly when, in the previous cycle, some flag was set with its `irq_mask` bit set. Bit positions are the same as in R2.
- R10: `fault_crit` is high while the sequence error is set with `map_seq` = 1, or the timing error is set with `map_tim` = 1. `fault_noncrit` covers the same errors when their map bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_err_evt | input | 1 | Sequence-error pulse |
| tim_err_evt | input | 1 | Timing-error pulse |
| err_algo | input | 1 | Algorithm of the error (0 = A, 1 = B) |
| err_step | input | STEP_W | Step index of the error |
| eoc_evt | input | 1 | End-of-conversion pulse |
| eoc_is_selftest | input | 1 | Conversion belongs to the self-test channel |
| eoc_mask | input | 1 | Enables capture of self-test end-of-conversion |
| algo_a_done | input | 1 | Last step of algorithm A executed |
| algo_b_done | input | 1 | Last step of algorithm B executed |
| algo_a_wden | input | 1 | Watchdog enable for algorithm A |
| algo_b_wden | input | 1 | Watchdog enable for algorithm B |
| ovr_en | input | 1 | Overwrite policy: 1 replace, 0 discard |
| irq_mask | input | 6 | Per-flag interrupt enables |
| map_seq | input | 1 | Sequence error to critical (1) or non-critical (0) |
| map_tim | input | 1 | Timing error to critical (1) or non-critical (0) |
| wr_en | input | 1 | Write strobe for write-1-to-clear |
| wr_data | input | 6 | Write-1-to-clear data |
| flags | output | 6 | Sticky status flags |
| step_a | output | STEP_W | Step field of algorithm A |
| step_b | output | STEP_W | Step field of algorithm B |
| irq | output | 1 | Registered masked interrupt request |
| fault_crit | output | 1 | Critical fault level |
| fault_noncrit | output | 1 | Non-critical fault level |

## Verification
The embedded assertions check, on every cycle, a set of relations that hold regardless of the scenario:
- the one-cycle lag of the interrupt behind the masked flags;
- clearing by write-1;
- gating of the end-of-algorithm flags;
- setting of the overwrite flag;
- step fields held still under the discard policy.

Some behaviours need stimulus sequences, and only the bench's scenarios can show them:
- the replace policy rewriting the error flags;
- set beating clear in the same cycle;
- the gating of the self-test end-of-conversion flag;
- fault steering as the map bits change.

A behavioural reference model, compared on every clock across a long random run, covers the combinations of these.

// File: rtl/selftest_status_reg.sv
module selftest_status_reg #(
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_err_evt,
  input  logic              tim_err_evt,
  input  logic              err_algo,
  input  logic [STEP_W-1:0] err_step,
  input  logic              eoc_evt,
  input  logic              eoc_is_selftest,
  input  logic              eoc_mask,
  input  logic              algo_a_done,
  input  logic              algo_b_done,
  input  logic              algo_a_wden,
  input  logic              algo_b_wden,
  input  logic              ovr_en,
  input  logic [5:0]        irq_mask,
  input  logic              map_seq,
  input  logic              map_tim,
  input  logic              wr_en,
  input  logic [5:0]        wr_data,
  output logic [5:0]        flags,
  output logic [STEP_W-1:0] step_a,
  output logic [STEP_W-1:0] step_b,
  output logic              irq,
  output logic              fault_crit,
  output logic              fault_noncrit
);
  localparam int F_SEQ = 0;
  localparam int F_TIM = 1;
  localparam int F_OVR = 2;
  localparam int F_EOC = 3;
  localparam int F_EOA = 4;
  localparam int F_EOB = 5;

  logic [5:0] clr, kept, flags_d;
  logic [1:0] err_evt;
  logic       any_err, pending, take;
  logic       set_eoc, set_eoa, set_eob;

  assign clr     = wr_en ? wr_data : 6'b0;
  assign kept    = flags & ~clr;
  assign err_evt = {tim_err_evt, seq_err_evt};
  assign any_err = |err_evt;
  assign pending = |kept[F_TIM:F_SEQ];
  assign take    = any_err && (!pending || ovr_en);
  assign set_eoc = eoc_evt && eoc_is_selftest && eoc_mask;
  assign set_eoa = algo_a_done && algo_a_wden;
  assign set_eob = algo_b_done && algo_b_wden;

  always_comb begin
    flags_d = kept;
    if (take) flags_d[F_TIM:F_SEQ] = err_evt;
    if (any_err && pending) flags_d[F_OVR] = 1'b1;
    if (set_eoc) flags_d[F_EOC] = 1'b1;
    if (set_eoa) flags_d[F_EOA] = 1'b1;
    if (set_eob) flags_d[F_EOB] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      step_a <= '0;
      step_b <= '0;
      irq    <= 1'b0;
    end else begin
      flags <= flags_d;
      irq   <= |(flags & irq_mask);
      if (take && !err_algo) step_a <= err_step;
      if (take &&  err_algo) step_b <= err_step;
    end
  end

  assign fault_crit    = (flags[F_SEQ] &&  map_seq) || (flags[F_TIM] &&  map_tim);
  assign fault_noncrit = (flags[F_SEQ] && !map_seq) || (flags[F_TIM] && !map_tim);

  // R9
  irq_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & irq_mask)) |=> irq);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags & irq_mask)) |=> !irq);

  // R2
  w1c_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[F_EOC] && !eoc_evt) |=> !flags[F_EOC]);

  // R5
  overwrite_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && pending) |=> flags[F_OVR]);

  // R6
  discard_keeps_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && pending && !ovr_en) |=> ($stable(step_a) && $stable(step_b)));

  // R8
  eoa_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_EOA]) |-> $past(algo_a_done && algo_a_wden));

  // R8
  eob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_EOB]) |-> $past(algo_b_done && algo_b_wden));

  // R10
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_crit || fault_noncrit) |-> (flags[F_SEQ] || flags[F_TIM]));
endmodule

// File: tb/selftest_status_reg_bench.sv
`timescale 1ns/1ps
module selftest_status_reg_bench;
  localparam int SW = 5;
  logic clk = 0, rst_n = 0;
  logic seq_err_evt = 0, tim_err_evt = 0, err_algo = 0;
  logic [SW-1:0] err_step = 0;
  logic eoc_evt = 0, eoc_is_selftest = 0, eoc_mask = 0;
  logic algo_a_done = 0, algo_b_done = 0, algo_a_wden = 0, algo_b_wden = 0;
  logic ovr_en = 0, map_seq = 0, map_tim = 0, wr_en = 0;
  logic [5:0] irq_mask = 0, wr_data = 0;
  logic [5:0] flags;
  logic [SW-1:0] step_a, step_b;
  logic irq, fault_crit, fault_noncrit;

  int checks = 0, failures = 0;
  bit model_on = 0, done = 0;

  logic [5:0] m_flags = 0;
  logic [SW-1:0] m_sa = 0, m_sb = 0;
  logic m_irq = 0;

  always #2.5 clk = ~clk;

  selftest_status_reg #(.STEP_W(SW)) u_selftest_status_reg (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 0; m_sa = 0; m_sb = 0; m_irq = 0;
    end else begin
      logic [5:0] c, nf;
      bit pend, any, tk;
      c    = wr_en ? wr_data : 6'd0;
      nf   = m_flags & ~c;
      any  = seq_err_evt || tim_err_evt;
      pend = (nf[0] == 1) || (nf[1] == 1);
      tk   = any && (!pend || ovr_en);
      m_irq = (m_flags & irq_mask) != 0;
      if (tk) begin
        nf[0] = seq_err_evt; nf[1] = tim_err_evt;
        if (err_algo) m_sb = err_step; else m_sa = err_step;
      end
      if (any && pend) nf[2] = 1;
      if (eoc_evt && eoc_is_selftest && eoc_mask) nf[3] = 1;
      if (algo_a_done && algo_a_wden) nf[4] = 1;
      if (algo_b_done && algo_b_wden) nf[5] = 1;
      m_flags = nf;
    end
  end

  always @(negedge clk) if (model_on && rst_n) begin
    chk("R3 flags", flags, m_flags);
    chk("R6 step_a", step_a, m_sa);
    chk("R6 step_b", step_b, m_sb);
    chk("R9 irq", irq, m_irq);
    chk("R10 crit", fault_crit, (m_flags[0] && map_seq) || (m_flags[1] && map_tim));
    chk("R10 noncrit", fault_noncrit, (m_flags[0] && !map_seq) || (m_flags[1] && !map_tim));
  end

  task automatic tick();
    @(posedge clk); #1;
    seq_err_evt = 0; tim_err_evt = 0; eoc_evt = 0;
    algo_a_done = 0; algo_b_done = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 6'h3f; tick();
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flags", flags, 0);
    chk("R1 steps", {step_a, step_b}, 0);
    chk("R1 outs", {irq, fault_crit, fault_noncrit}, 0);
    rst_n = 1; model_on = 1;
    tick();

    // R3: sequence error for algorithm A, step 3
    seq_err_evt = 1; err_algo = 0; err_step = 3; tick();
    chk("R3 seq flag", flags, 6'h01);
    chk("R3 step_a", step_a, 3);

    // R2: writing zeros has no effect, writing one clears
    wr_en = 1; wr_data = 6'h00; tick();
    chk("R2 write0", flags, 6'h01);
    wr_en = 1; wr_data = 6'h01; tick();
    chk("R2 write1", flags, 6'h00);

    // R5/R6: discard policy
    ovr_en = 0;
    tim_err_evt = 1; err_algo = 1; err_step = 7; tick();
    seq_err_evt = 1; err_algo = 1; err_step = 12; tick();
    chk("R5 ovr flag", flags, 6'h06);
    chk("R6 discard step_b", step_b, 7);

    // R6: replace policy
    ovr_en = 1;
    seq_err_evt = 1; err_algo = 0; err_step = 9; tick();
    chk("R6 replace flags", flags, 6'h05);
    chk("R6 replace step_a", step_a, 9);
    clear_all();

    // R5: clear and new error in the same cycle -> no overwrite
    seq_err_evt = 1; err_step = 1; tick();
    wr_en = 1; wr_data = 6'h01; tim_err_evt = 1; tick();
    chk("R5 no ovr when cleared", flags, 6'h02);
    clear_all();

    // R7: gating of self-test end-of-conversion
    eoc_evt = 1; eoc_is_selftest = 1; eoc_mask = 0; tick();
    chk("R7 mask off", flags, 0);
    eoc_evt = 1; eoc_is_selftest = 0; eoc_mask = 1; tick();
    chk("R7 not selftest", flags, 0);
    eoc_evt = 1; eoc_is_selftest = 1; eoc_mask = 1; tick();
    chk("R7 set", flags, 6'h08);

    // R4: set wins over same-cycle clear
    eoc_evt = 1; wr_en = 1; wr_data = 6'h08; tick();
    chk("R4 set wins", flags, 6'h08);
    clear_all();

    // R8: end-of-algorithm gating
    algo_a_done = 1; algo_a_wden = 0; algo_b_done = 1; algo_b_wden = 1; tick();
    chk("R8 gate", flags, 6'h20);
    algo_a_done = 1; algo_a_wden = 1; tick();
    chk("R8 set A", flags, 6'h30);

    // R9: masked irq, one cycle lag
    irq_mask = 6'h01; tick();
    chk("R9 masked off", irq, 0);
    irq_mask = 6'h10; tick(); tick();
    chk("R9 masked on", irq, 1);
    clear_all(); tick();
    chk("R9 cleared", irq, 0);

    // R10: fault steering
    map_seq = 1; map_tim = 0;
    seq_err_evt = 1; tick();
    chk("R10 seq crit", {fault_crit, fault_noncrit}, 2'b10);
    map_seq = 0; #1;
    chk("R10 seq noncrit", {fault_crit, fault_noncrit}, 2'b01);
    clear_all();

    // random run against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      seq_err_evt = (r[2:0] == 0); tim_err_evt = (r[5:3] == 0);
      err_algo = r[6]; err_step = r[11:7];
      eoc_evt = r[12]; eoc_is_selftest = r[13]; eoc_mask = r[14];
      algo_a_done = (r[17:15] == 0); algo_b_done = (r[20:18] == 0);
      algo_a_wden = r[21]; algo_b_wden = r[22];
      ovr_en = r[23]; map_seq = r[24]; map_tim = r[25];
      wr_en = (r[28:26] == 0); wr_data = 6'($urandom);
      irq_mask = (r[29]) ? 6'($urandom) : irq_mask;
      tick();
    end
    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule